// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves 36-bit words from a write clock domain to an independent read clock domain. The two clocks may run at any ratio or phase. The write side sees a ready flag and an active-low almost-full flag. The read side sees a registered output word with an output-ready flag and an active-low almost-empty flag. Storage is an inferred register file of `2**AW` words. A registered output stage after it holds one extra word. Pointers cross between domains as Gray codes through two-flop synchronizers.

Each port follows a valid/ready rule. A port's request is valid when its select is low and its enable is high. A transfer happens on that port's rising clock edge only if the matching ready (`in_rdy` or `out_rdy`) is also high. A valid request that meets a low ready has no effect. The source need not hold it, and may retry on any later edge.

The two 11-bit level thresholds are the empty-side threshold X and the full-side threshold Y. They are set once after each reset, by the method that the two select pins choose at reset release. Normal writes stay blocked until the thresholds are set.

Top module: `dual_clk_fifo`

## Requirements
- R1: A port transfers only on a rising edge of its own clock with its select low, its enable high and its ready high. A request with the select high, or the enable low, changes nothing.
- R2: Words leave the read port in the order they were accepted, with every bit unchanged.
- R3: `in_rdy` is low during reset and while the array holds `2**AW` words that have not yet moved into the output register. With the output register full, the block holds `2**AW + 1` words in total.
- R4: After a word is written into an empty FIFO, `out_rdy` rises on the third read-clock edge after that write edge, and `rd_data` holds that word from the same edge.
- R5: While `out_rdy` is high and no read is accepted, `out_rdy` stays high and `rd_data` holds its value. `out_rdy` is low during reset and when nothing is stored.
- R6: Once the flags have settled, `ae_n` is low exactly when the stored count (array words plus the output-register word) is at most X.
- R7: Once the flags have settled, `af_n` is low exactly when the free array count (`2**AW` minus the array words not yet fetched) is at most Y.
- R8: The method is taken from {`ofs_sel_hi`, `ofs_sel_lo`} as they stand at reset release: 00 serial, 01 parallel, 10 sets X = Y = 8, 11 sets X = Y = 16.
- R9: In serial mode, each write-clock edge with `ofs_sel_hi` low shifts in `ofs_sel_lo`. Edges with `ofs_sel_hi` high shift nothing. After 22 bits, the first bit is the MSB of Y and the last bit is the LSB of X.
- R10: In parallel mode, the first two valid write-port requests load X and then Y from `wr_data[10:0]`. These two words are not stored.
- R11: Normal writes made before the thresholds are set are ignored and never reach the read port.
- R12: Each pointer's Gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both domains |
| ofs_sel_hi | input | 1 | Method select high bit at reset; serial shift enable (active low) afterwards |
| ofs_sel_lo | input | 1 | Method select low bit at reset; serial data bit afterwards |
| wr_cs_n | input | 1 | Write-port select, active low |
| wr_en | input | 1 | Write-port enable |
| wr_data | input | 36 | Write word; bits [10:0] carry thresholds in parallel mode |
| in_rdy | output | 1 | Write ready; low when full, in reset or before thresholds are set |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| rd_cs_n | input | 1 | Read-port select, active low |
| rd_en | input | 1 | Read-port enable |
| rd_data | output | 36 | Registered output word |
| out_rdy | output | 1 | Output word valid |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The assertions assume that reset stays low for at least four edges of each clock. They also assume that the select pins are steady around reset release, and that the serial enable is held high from release until the shift sequence starts. The bench drives every input at the falling edge of the clock that samples it. It holds reset for six cycles and changes the select pins only while reset is low or at the release edge itself. The level-flag checks are made only after both synchronizers have had at least ten idle cycles, because the count on either side lags the far side by the synchronizer depth.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int OFS_W    = 11;
  localparam int SER_BITS = 2 * OFS_W;
  localparam int SER_CW   = $clog2(SER_BITS);
  localparam logic [OFS_W-1:0] PRESET_LO = OFS_W'(8);
  localparam logic [OFS_W-1:0] PRESET_HI = OFS_W'(16);

  typedef enum logic [1:0] {
    MODE_SERIAL   = 2'b00,
    MODE_PARALLEL = 2'b01,
    MODE_PRE_LO   = 2'b10,
    MODE_PRE_HI   = 2'b11
  } ofs_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_out[i] = ^stab_q[W-1:i];
  end
endmodule

// File: rtl/dcf_offset_prog.sv
module dcf_offset_prog
  import dcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             strobe,
  input  logic [OFS_W-1:0] data_lo,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs,
  output logic             done
);
  ofs_mode_e             mode_q;
  logic [SER_BITS-1:0]   shreg_q;
  logic [SER_CW-1:0]     cnt_q;
  logic                  pstep_q;
  logic [SER_BITS-1:0]   shnext;

  // The method select is sampled on every edge while reset is low, so it
  // holds the value present at release.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ofs_mode_e'({sel_hi, sel_lo});
  end

  assign shnext = {shreg_q[SER_BITS-2:0], sel_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_ofs   <= '0;
      y_ofs   <= '0;
      done    <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
      pstep_q <= 1'b0;
    end else if (!done) begin
      unique case (mode_q)
        MODE_PRE_LO: begin
          x_ofs <= PRESET_LO;
          y_ofs <= PRESET_LO;
          done  <= 1'b1;
        end
        MODE_PRE_HI: begin
          x_ofs <= PRESET_HI;
          y_ofs <= PRESET_HI;
          done  <= 1'b1;
        end
        MODE_PARALLEL: begin
          if (strobe) begin
            if (!pstep_q) begin
              x_ofs   <= data_lo;
              pstep_q <= 1'b1;
            end else begin
              y_ofs <= data_lo;
              done  <= 1'b1;
            end
          end
        end
        default: begin
          if (!sel_hi) begin
            shreg_q <= shnext;
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == SER_CW'(SER_BITS - 1)) begin
              y_ofs <= shnext[SER_BITS-1:OFS_W];
              x_ofs <= shnext[OFS_W-1:0];
              done  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DW-1:0]    wr_data,
  input  logic             prog_done,
  input  logic [OFS_W-1:0] y_ofs,
  input  logic [AW:0]      rd_bin_sync,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_word,
  output logic             in_rdy,
  output logic             af_n,
  output logic [AW:0]      wr_bin,
  output logic [AW:0]      wr_gray
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   level, free_cnt, wr_next;
  logic          push;

  assign level    = wr_bin - rd_bin_sync;
  assign free_cnt = (AW+1)'(DEPTH) - level;
  assign in_rdy   = prog_done && (level != (AW+1)'(DEPTH));
  assign push     = req && in_rdy;
  assign wr_next  = wr_bin + 1'b1;
  assign af_n     = !(32'(free_cnt) <= 32'(y_ofs));
  assign rd_word  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_bin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (push) begin
      wr_bin  <= wr_next;
      wr_gray <= wr_next ^ (wr_next >> 1);
    end
  end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [AW:0]      wr_bin_sync,
  input  logic [OFS_W-1:0] x_ofs,
  input  logic [DW-1:0]    rd_word,
  output logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             out_rdy,
  output logic             ae_n,
  output logic [AW:0]      rd_gray
);
  logic [AW:0]   rd_bin, rd_next, arr_cnt;
  logic [AW+1:0] stored;
  logic          avail, pop, load;

  assign avail   = (rd_bin != wr_bin_sync);
  assign pop     = req && out_rdy;
  assign load    = avail && (!out_rdy || pop);
  assign rd_next = rd_bin + 1'b1;
  assign rd_addr = rd_bin[AW-1:0];
  assign arr_cnt = wr_bin_sync - rd_bin;
  assign stored  = {1'b0, arr_cnt} + {{(AW+1){1'b0}}, out_rdy};
  assign ae_n    = !(32'(stored) <= 32'(x_ofs));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      rd_data <= '0;
      out_rdy <= 1'b0;
    end else if (load) begin
      rd_data <= rd_word;
      rd_bin  <= rd_next;
      rd_gray <= rd_next ^ (rd_next >> 1);
      out_rdy <= 1'b1;
    end else if (pop) begin
      out_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import dcf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ofs_sel_hi,
  input  logic          ofs_sel_lo,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          in_rdy,
  output logic          af_n,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          out_rdy,
  output logic          ae_n
);
  logic [OFS_W-1:0] x_ofs, y_ofs;
  logic             prog_done;
  logic [AW:0]      wr_bin, wr_gray, rd_gray, rd_bin_w, wr_bin_r;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_word;
  logic             wr_req, rd_req;

  assign wr_req = !wr_cs_n && wr_en;
  assign rd_req = !rd_cs_n && rd_en;

  dcf_offset_prog u_prog (
    .clk(wclk), .rst_n(rst_n), .sel_hi(ofs_sel_hi), .sel_lo(ofs_sel_lo),
    .strobe(wr_req), .data_lo(wr_data[OFS_W-1:0]),
    .x_ofs(x_ofs), .y_ofs(y_ofs), .done(prog_done)
  );

  dcf_wr_ctrl #(.DW(DW), .AW(AW)) u_wr (
    .clk(wclk), .rst_n(rst_n), .req(wr_req), .wr_data(wr_data),
    .prog_done(prog_done), .y_ofs(y_ofs), .rd_bin_sync(rd_bin_w),
    .rd_addr(rd_addr), .rd_word(rd_word), .in_rdy(in_rdy), .af_n(af_n),
    .wr_bin(wr_bin), .wr_gray(wr_gray)
  );

  dcf_gray_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_r)
  );

  dcf_gray_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_w)
  );

  dcf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .req(rd_req), .wr_bin_sync(wr_bin_r),
    .x_ofs(x_ofs), .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_rdy(out_rdy), .ae_n(ae_n), .rd_gray(rd_gray)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_cs_n,
  input logic          rd_en,
  input logic          out_rdy,
  input logic [DW-1:0] rd_data,
  input logic          in_rdy,
  input logic          prog_done,
  input logic [AW:0]   wr_bin,
  input logic [AW:0]   rd_bin_w,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   rd_gray
);
  localparam int DEPTH = 1 << AW;
  logic [AW:0] lvl;
  assign lvl = wr_bin - rd_bin_w;

  // R5
  held_out_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_rdy && !(!rd_cs_n && rd_en)) |=> (out_rdy && $stable(rd_data)));

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    32'(lvl) <= 32'(DEPTH));

  // R3
  blocked_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !in_rdy |=> (wr_bin == $past(wr_bin)));

  // R11
  unprog_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !prog_done |=> $stable(wr_bin));

  // R8
  prog_sticky_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    prog_done |=> prog_done);

  // R12
  wr_gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R12
  rd_gray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dual_clk_fifo dcf_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
  .out_rdy(out_rdy), .rd_data(rd_data), .in_rdy(in_rdy),
  .prog_done(prog_done), .wr_bin(wr_bin), .rd_bin_w(rd_bin_w),
  .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/dual_clk_fifo_tb.sv
module dual_clk_fifo_tb;
  localparam int DW = 36;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic ofs_sel_hi = 1, ofs_sel_lo = 0;
  logic wr_cs_n = 1, wr_en = 0, rd_cs_n = 1, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic in_rdy, af_n, out_rdy, ae_n;

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];

  dual_clk_fifo #(.DW(DW), .AW(AW)) u_dut (.*);

  always #10 wclk = ~wclk;
  initial begin #5; forever #10 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ae_n(int n, int x);
    return !(n <= x);
  endfunction

  function automatic logic exp_af_n(int n, int y);
    int fr;
    fr = DEPTH - ((n > 0) ? n - 1 : 0);
    return !(fr <= y);
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {4'($urandom), $urandom};
  endfunction

  task automatic do_reset(input logic [1:0] mode);
    @(negedge wclk);
    rst_n = 0; {ofs_sel_hi, ofs_sel_lo} = mode;
    wr_cs_n = 1; wr_en = 0; rd_cs_n = 1; rd_en = 0;
    repeat (6) @(negedge wclk);
    // R3 R5: outputs during reset
    chk(in_rdy == 0, "R3 reset in_rdy", in_rdy, 0);
    chk(out_rdy == 0, "R5 reset out_rdy", out_rdy, 0);
    rst_n = 1; ofs_sel_hi = 1;
    q.delete();
    repeat (3) @(negedge wclk);
  endtask

  task automatic try_write(input logic [DW-1:0] d, output bit ok);
    @(negedge wclk);
    ok = in_rdy;
    if (ok) begin
      wr_cs_n = 0; wr_en = 1; wr_data = d; q.push_back(d);
      @(posedge wclk); #1;
      wr_cs_n = 1; wr_en = 0;
    end
  endtask

  task automatic write_n(input int k);
    bit ok;
    for (int i = 0; i < k; i++) begin
      ok = 0;
      while (!ok) try_write(rnd_word(), ok);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic flags_chk(input int x, input int y, input string tag);
    settle();
    chk(ae_n == exp_ae_n(q.size(), x), {"R6 ae_n ", tag}, ae_n, exp_ae_n(q.size(), x));
    chk(af_n == exp_af_n(q.size(), y), {"R7 af_n ", tag}, af_n, exp_af_n(q.size(), y));
  endtask

  task automatic read_one();
    @(negedge rclk);
    while (!out_rdy) @(negedge rclk);
    chk(rd_data == q[0], "R2 read order", rd_data, q[0]);
    void'(q.pop_front());
    rd_cs_n = 0; rd_en = 1;
    @(posedge rclk); #1;
    rd_cs_n = 1; rd_en = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) read_one();
    settle();
    chk(out_rdy == 0, "R5 empty out_rdy", out_rdy, 0);
    chk(ae_n == 0, "R6 empty ae_n", ae_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit ok;
    void'($urandom(32'd2024));

    // ---- preset 8 (R8), fall-through R4, fill R3, flags R6/R7
    do_reset(2'b10);
    chk(in_rdy == 1, "R8 preset done in_rdy", in_rdy, 1);
    d = rnd_word();
    @(negedge wclk);
    wr_cs_n = 0; wr_en = 1; wr_data = d; q.push_back(d);
    @(posedge wclk); #1;
    wr_cs_n = 1; wr_en = 0;
    @(posedge rclk); @(posedge rclk); #2;
    chk(out_rdy == 0, "R4 not before third edge", out_rdy, 0);
    @(posedge rclk); #2;
    chk(out_rdy == 1, "R4 third edge out_rdy", out_rdy, 1);
    chk(rd_data == d, "R4 word present", rd_data, d);
    // R1: read request with select high is ignored
    @(negedge rclk); rd_cs_n = 1; rd_en = 1;
    repeat (3) @(negedge rclk);
    rd_en = 0;
    chk(out_rdy == 1 && rd_data == d, "R1 read with select high", rd_data, d);
    // R1: write request with select high is ignored
    @(negedge wclk); wr_cs_n = 1; wr_en = 1; wr_data = rnd_word();
    repeat (3) @(negedge wclk);
    wr_en = 0;
    write_n(7);
    flags_chk(8, 8, "count 8 x8");
    write_n(1);
    flags_chk(8, 8, "count 9 x8");
    write_n(56 - 9);
    flags_chk(8, 8, "count 56 y8");
    write_n(1);
    flags_chk(8, 8, "count 57 y8");
    begin
      int miss = 0;
      while (miss < 10) begin
        try_write(rnd_word(), ok);
        miss = ok ? 0 : miss + 1;
      end
    end
    chk(q.size() == DEPTH + 1, "R3 capacity", q.size(), DEPTH + 1);
    chk(in_rdy == 0, "R3 full in_rdy", in_rdy, 0);
    drain();

    // ---- serial programming: X=5, Y=59 (R9, R11)
    do_reset(2'b00);
    @(negedge wclk); wr_cs_n = 0; wr_en = 1; wr_data = rnd_word();
    repeat (3) @(negedge wclk);
    chk(in_rdy == 0, "R11 not ready before programming", in_rdy, 0);
    wr_cs_n = 1; wr_en = 0;
    begin
      logic [21:0] bits;
      bits = {11'd59, 11'd5};
      for (int i = 21; i >= 0; i--) begin
        @(negedge wclk); ofs_sel_hi = 0; ofs_sel_lo = bits[i];
        @(negedge wclk); ofs_sel_hi = 1; ofs_sel_lo = 1'($urandom);
      end
    end
    settle();
    chk(out_rdy == 0, "R11 early write dropped", out_rdy, 0);
    chk(in_rdy == 1, "R9 programming complete", in_rdy, 1);
    write_n(5);
    flags_chk(5, 59, "serial count 5");
    write_n(1);
    flags_chk(5, 59, "serial count 6");
    drain();

    // ---- parallel programming: X=3, Y=62 (R10)
    do_reset(2'b01);
    @(negedge wclk); wr_cs_n = 0; wr_en = 1; wr_data = {25'($urandom), 11'd3};
    @(negedge wclk); wr_data = {25'($urandom), 11'd62};
    @(negedge wclk); wr_cs_n = 1; wr_en = 0;
    settle();
    chk(out_rdy == 0, "R10 program words not stored", out_rdy, 0);
    chk(in_rdy == 1, "R10 programming complete", in_rdy, 1);
    write_n(2);
    flags_chk(3, 62, "parallel count 2");
    write_n(2);
    flags_chk(3, 62, "parallel count 4");
    drain();

    // ---- preset 16 then random traffic (R8, R1, R2)
    do_reset(2'b11);
    write_n(16);
    flags_chk(16, 16, "preset16 count 16");
    write_n(1);
    flags_chk(16, 16, "preset16 count 17");
    drain();
    fork
      begin : wr_side
        int sent = 0;
        while (sent < 400) begin
          int r;
          @(negedge wclk);
          r = int'($urandom % 10);
          wr_cs_n = (r == 0); wr_en = (r < 7); wr_data = rnd_word();
          if (!wr_cs_n && wr_en && in_rdy) begin q.push_back(wr_data); sent++; end
        end
        @(negedge wclk); wr_cs_n = 1; wr_en = 0;
      end
      begin : rd_side
        int got = 0;
        while (got < 400) begin
          @(negedge rclk);
          rd_cs_n = ($urandom % 10 == 0); rd_en = 1'($urandom);
          if (!rd_cs_n && rd_en && out_rdy) begin
            chk(rd_data == q[0], "R1 R2 random read", rd_data, q[0]);
            void'(q.pop_front());
            got++;
          end
        end
        @(negedge rclk); rd_cs_n = 1; rd_en = 0;
      end
    join
    settle();
    chk(out_rdy == 0, "R2 all words delivered", out_rdy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule